// File: doc/BRIEF.md
# External-Data Access Router with Auxiliary RAM

This block sits on the path that carries the external-data move accesses of an 8-bit microcontroller. For each read or write it decides where the access goes. It is served either by a 256-byte on-chip auxiliary RAM or by the external bus interface. The access carries one of two kinds of pointer: an 8-bit register pointer or a 16-bit data pointer. An 8-bit pointer is zero-extended before the block tests its address range.

A chip control register gates the auxiliary RAM with a single enable bit, and that bit is clear after reset. While the bit is clear, every access goes to the external bus. While the bit is set, accesses whose effective address is 0 to 255 stay on chip and all higher addresses go out. The other control bits are plain storage that reads back unchanged. The timing of the external bus lies outside this block: the block only raises the request together with its address, data and direction.

Top module: `xdata_router`

## Requirements
- R1: After reset, the control register reads 0x00, the auxiliary RAM is disabled, and no RAM strobe, external request or read-valid is active while the access strobes are low.
- R2: A cycle with `ctrlWe` high stores `ctrlWdata` into the control register. Bit 4 is the auxiliary RAM enable, and the new value applies from the next cycle on.
- R3: With bit 4 clear, every access goes to the external bus (`extReq` high, both RAM strobes low), including effective addresses 0 to 255.
- R4: With bit 4 set, an access whose effective address is above 255 goes to the external bus.
- R5: With bit 4 set, an access whose effective address is 0 to 255 is served by the auxiliary RAM: `ramRdStb` or `ramWrStb` is high and `extReq` stays low.
- R6: When `accWide` is 0 (8-bit pointer), the effective address is `{8'h00, accAddr[7:0]}`, and `accAddr[15:8]` has no effect on routing or on the RAM location.
- R7: An internal write completes in its strobe cycle. An internal read presents the stored byte on `rdData`, with `rdValid` high, in the cycle after `ramRdStb`.
- R8: An access never raises a RAM strobe and `extReq` in the same cycle.
- R9: Control register bits other than bit 4 are stored and read back unchanged on `ctrlRdata`, and they do not affect routing.
- R10: An external access drives `extAddr` with the effective address and `extWdata` with `wrData`. `extWe` is 1 for a write and 0 for a read.
- R11: If `rdStb` and `wrStb` are high together, the access is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control register write enable |
| ctrlWdata | input | 8 | Control register write data |
| ctrlRdata | output | 8 | Control register contents |
| accWide | input | 1 | 1 = 16-bit data pointer, 0 = 8-bit register pointer |
| accAddr | input | 16 | Access pointer value |
| wrData | input | 8 | Write data |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| rdData | output | 8 | Internal read data |
| rdValid | output | 1 | Internal read data valid |
| ramRdStb | output | 1 | Auxiliary RAM read strobe |
| ramWrStb | output | 1 | Auxiliary RAM write strobe |
| extReq | output | 1 | External bus request |
| extWe | output | 1 | External request is a write |
| extAddr | output | 16 | External request address |
| extWdata | output | 8 | External request write data |

## Verification
The routing decision is tried at addresses on both sides of the 255/256 boundary, with the enable bit clear and then set. This shows whether the address test and the enable gate each act on their own. Byte-pointer accesses carry nonzero upper pointer bits, which would show up as wrong routing or aliased RAM locations if zero-extension failed. Control values with every bit except the enable set, and then with all bits set, separate the enable bit from plain storage. Overlapping read and write strobes, together with reads of bytes written earlier at 0x00, 0xFF and middle addresses, confirm the write priority and the one-cycle read latency.

// File: rtl/xdata_router_pkg.sv
package xdata_router_pkg;

  // Decoded strobes passed from control to datapath
  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic extRd;
    logic extWr;
  } routeStrb_t;

endpackage

// File: rtl/xdata_router_ctrl.sv
module xdata_router_ctrl
  import xdata_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 8,
  parameter int CTRL_W    = 8,
  parameter int EN_BIT    = 4,
  parameter int RAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              accWide,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic [ADDR_W-1:0] effAddr,
  output routeStrb_t        strb
);

  localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_DEPTH);

  logic [CTRL_W-1:0] ctrlReg;
  logic              auxEn;
  logic              inRange;
  logic              hit;
  logic              doWr;
  logic              doRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end

  assign ctrlRdata = ctrlReg;
  assign auxEn     = ctrlReg[EN_BIT];

  // Pointer width selects zero-extension
  always_comb begin
    if (accWide) effAddr = accAddr;
    else         effAddr = {{(ADDR_W-PTR_W){1'b0}}, accAddr[PTR_W-1:0]};
  end

  assign inRange = (effAddr < RAM_TOP);
  assign hit     = auxEn && inRange;
  assign doWr    = wrStb;
  assign doRd    = rdStb && !wrStb;

  always_comb begin
    strb.ramRd = doRd && hit;
    strb.ramWr = doWr && hit;
    strb.extRd = doRd && !hit;
    strb.extWr = doWr && !hit;
  end

  AST_DISABLED_EXTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRdata[EN_BIT] && (rdStb || wrStb)) |-> ((strb.extRd || strb.extWr) && !strb.ramRd && !strb.ramWr)); // R3

  AST_HIGH_EXTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb || wrStb) && accWide && (accAddr >= RAM_TOP)) |-> (strb.extRd || strb.extWr)); // R4

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWe |=> $stable(ctrlRdata)); // R9

  AST_WRITE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && wrStb) |-> (!strb.ramRd && !strb.extRd)); // R11

endmodule

// File: rtl/xdata_router_dp.sv
module xdata_router_dp
  import xdata_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeStrb_t        strb,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              ramRdStb,
  output logic              ramWrStb,
  output logic              extReq,
  output logic              extWe,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata
);

  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [RAM_AW-1:0] ramIdx;

  assign ramIdx = effAddr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (strb.ramWr) mem[ramIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.ramRd;
      if (strb.ramRd) rdData <= mem[ramIdx];
    end
  end

  assign ramRdStb = strb.ramRd;
  assign ramWrStb = strb.ramWr;
  assign extReq   = strb.extRd || strb.extWr;
  assign extWe    = strb.extWr;
  assign extAddr  = effAddr;
  assign extWdata = wrData;

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rstN)
    !((ramRdStb || ramWrStb) && extReq)); // R8

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ramRdStb |=> rdValid); // R7

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !ramRdStb |=> !rdValid); // R7

endmodule

// File: rtl/xdata_router.sv
module xdata_router
  import xdata_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int CTRL_W    = 8,
  parameter int EN_BIT    = 4,
  parameter int RAM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              accWide,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              ramRdStb,
  output logic              ramWrStb,
  output logic              extReq,
  output logic              extWe,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata
);

  routeStrb_t        strb;
  logic [ADDR_W-1:0] effAddr;

  xdata_router_ctrl #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CTRL_W(CTRL_W),
    .EN_BIT(EN_BIT), .RAM_DEPTH(RAM_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .accWide(accWide), .accAddr(accAddr),
    .rdStb(rdStb), .wrStb(wrStb),
    .effAddr(effAddr), .strb(strb)
  );

  xdata_router_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .effAddr(effAddr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid),
    .ramRdStb(ramRdStb), .ramWrStb(ramWrStb),
    .extReq(extReq), .extWe(extWe),
    .extAddr(extAddr), .extWdata(extWdata)
  );

endmodule

// File: tb/xdata_router_bench.sv
`timescale 1ns/1ps
module xdata_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic [7:0]  ctrlRdata;
  logic        accWide = 1'b1;
  logic [15:0] accAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [7:0]  rdData;
  logic        rdValid, ramRdStb, ramWrStb, extReq, extWe;
  logic [15:0] extAddr;
  logic [7:0]  extWdata;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  xdata_router u_xdata_router (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .accWide(accWide), .accAddr(accAddr),
    .wrData(wrData), .rdStb(rdStb), .wrStb(wrStb), .rdData(rdData),
    .rdValid(rdValid), .ramRdStb(ramRdStb), .ramWrStb(ramWrStb),
    .extReq(extReq), .extWe(extWe), .extAddr(extAddr), .extWdata(extWdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0; #1;
  endtask

  // Drive an access at a negedge; combinational outputs are valid after #1
  task automatic startAcc(input logic wide, input logic [15:0] a, input logic [7:0] d,
                          input logic rd, input logic wr);
    @(negedge clk);
    accWide = wide; accAddr = a; wrData = d; rdStb = rd; wrStb = wr; #1;
  endtask

  task automatic endAcc();
    @(negedge clk); rdStb = 1'b0; wrStb = 1'b0; #1;
  endtask

  task automatic checkRoute(input string tag, input logic expInt, input logic isWr);
    check({tag, " ramWrStb"}, ramWrStb, expInt && isWr);
    check({tag, " ramRdStb"}, ramRdStb, expInt && !isWr);
    check({tag, " extReq"}, extReq, !expInt);
    check({tag, " R8 exclusive"}, (ramRdStb | ramWrStb) & extReq, 0);
  endtask

  task automatic intWrite(input logic wide, input logic [15:0] a, input logic [7:0] d, input string tag);
    startAcc(wide, a, d, 1'b0, 1'b1);
    checkRoute(tag, 1'b1, 1'b1);
    endAcc();
  endtask

  task automatic intRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    startAcc(1'b1, a, 8'h00, 1'b1, 1'b0);
    checkRoute(tag, 1'b1, 1'b0);
    endAcc();
    check({tag, " R7 rdValid"}, rdValid, 1);
    check({tag, " R7 rdData"}, rdData, exp);
    @(negedge clk); #1;
    check({tag, " R7 rdValid drop"}, rdValid, 0);
  endtask

  task automatic testReset();
    #1;
    check("R1 ctrlRdata", ctrlRdata, 8'h00);
    check("R1 ramRdStb", ramRdStb, 0);
    check("R1 ramWrStb", ramWrStb, 0);
    check("R1 extReq", extReq, 0);
    check("R1 rdValid", rdValid, 0);
  endtask

  task automatic testDisabled();
    startAcc(1'b1, 16'h0010, 8'h00, 1'b1, 1'b0);
    checkRoute("R3 read low addr", 1'b0, 1'b0);
    check("R10 extAddr rd", extAddr, 16'h0010);
    check("R10 extWe rd", extWe, 0);
    endAcc();
    check("R3 no rdValid", rdValid, 0);
    startAcc(1'b0, 16'h3322, 8'hC3, 1'b0, 1'b1);
    checkRoute("R3 byte write", 1'b0, 1'b1);
    check("R10 R6 extAddr wr", extAddr, 16'h0022);
    check("R10 extWe wr", extWe, 1);
    check("R10 extWdata", extWdata, 8'hC3);
    endAcc();
  endtask

  task automatic testEnable();
    writeCtrl(8'h10);
    check("R2 ctrlRdata", ctrlRdata, 8'h10);
    intWrite(1'b1, 16'h0033, 8'h5A, "R5 write 0x33");
    intRead(16'h0033, 8'h5A, "R5 read 0x33");
  endtask

  task automatic testBounds();
    intWrite(1'b1, 16'h0000, 8'h11, "R5 write 0x00");
    intWrite(1'b1, 16'h00FF, 8'hEE, "R5 write 0xFF");
    intRead(16'h0000, 8'h11, "R5 read 0x00");
    intRead(16'h00FF, 8'hEE, "R5 read 0xFF");
    startAcc(1'b1, 16'h0100, 8'h00, 1'b1, 1'b0);
    checkRoute("R4 read 0x100", 1'b0, 1'b0);
    check("R4 extAddr", extAddr, 16'h0100);
    endAcc();
    startAcc(1'b1, 16'hFF00, 8'h66, 1'b0, 1'b1);
    checkRoute("R4 write 0xFF00", 1'b0, 1'b1);
    check("R4 R10 extWe", extWe, 1);
    endAcc();
    intRead(16'h0000, 8'h11, "R4 0x100 did not alias 0x00");
  endtask

  task automatic testBytePtr();
    intWrite(1'b0, 16'hAB44, 8'h77, "R6 byte write upper bits set");
    intRead(16'h0044, 8'h77, "R6 zero-extended location");
    startAcc(1'b0, 16'hFF80, 8'h00, 1'b1, 1'b0);
    checkRoute("R6 byte read upper bits set", 1'b1, 1'b0);
    endAcc();
  endtask

  task automatic testOtherBits();
    writeCtrl(8'hEF);
    check("R9 readback 0xEF", ctrlRdata, 8'hEF);
    startAcc(1'b1, 16'h0010, 8'h00, 1'b1, 1'b0);
    checkRoute("R9 R3 other bits do not enable", 1'b0, 1'b0);
    endAcc();
    writeCtrl(8'hFF);
    check("R9 readback 0xFF", ctrlRdata, 8'hFF);
    intRead(16'h0033, 8'h5A, "R9 enabled with all bits");
  endtask

  task automatic testPriority();
    startAcc(1'b1, 16'h0050, 8'h99, 1'b1, 1'b1);
    checkRoute("R11 both strobes internal", 1'b1, 1'b1);
    endAcc();
    check("R11 no rdValid", rdValid, 0);
    intRead(16'h0050, 8'h99, "R11 write stored");
    startAcc(1'b1, 16'h0200, 8'h44, 1'b1, 1'b1);
    checkRoute("R11 both strobes external", 1'b0, 1'b1);
    check("R11 extWe", extWe, 1);
    endAcc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDisabled();
    testEnable();
    testBounds();
    testBytePtr();
    testOtherBits();
    testPriority();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule